// File: doc/BRIEF.md
# JTAG Debug Command Bridge

This block is a 16-bit user data register that sits behind a device's built-in JTAG controller. It turns that register into a small debug command port into internal logic. The controller supplies the register strobes (select, capture, shift, update), TCK and TDI, and the block drives TDO. Each scanned word carries three fields: a peripheral number, an operation and a data byte. Together these form a tiny memory-mapped bus. A write produces a one-cycle strobe in the system clock domain. A read stores the peripheral's byte, and the host collects it on the following scan.

There are four example peripherals:
- a virtual switch register, which stands in for board switches or LEDs;
- a read-only status port;
- a monitor select register, which routes one of sixteen internal signals to a pin;
- a test-mode enable register.

When a scan completes, the new command is copied into a holding register and a level toggles. The toggle crosses into the system domain through a synchroniser. A four-state sequencer there executes the command:
- `ST_IDLE` goes to `ST_DECODE` when a synchronised command pulse arrives.
- `ST_DECODE` goes to `ST_WRITE` for a write, to `ST_READ` for a read, and back to `ST_IDLE` for any other operation.
- `ST_WRITE` and `ST_READ` each last one cycle and then return to `ST_IDLE`.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: While select and shift are both high, each rising TCK edge moves the register one place toward bit 0, and TDI enters at bit 15. TDO always shows bit 0, so a word goes out and comes in least significant bit first.
- R2: When select and capture are high on a TCK edge, the register loads bits 15:8 with the upper byte of the last updated command and bits 7:0 with the last read result. Both are 0x00 after reset.
- R3: A word decodes as follows: bits 15:12 are the peripheral number, bits 11:8 the operation, and bits 7:0 the data. Operation 0x0 is a write. Each update of a write gives exactly one system-clock cycle of `per_wr_stb`, with the peripheral number on `per_wr_addr` and the data byte on `per_wr_data`.
- R4: Operation 0x1 is a read. The addressed peripheral's byte appears in bits 7:0 of the next capture.
- R5: Any operation other than 0x0 or 0x1 gives no strobe, changes no peripheral and leaves the stored read byte unchanged. It still updates the command byte returned by R2.
- R6: A command runs only on an update strobe. A scan that ends without update runs nothing, and it does not change the command byte returned on the next capture.
- R7: Peripheral 0 is the switch register. A write sets `sw_out`, and a read returns its value.
- R8: Peripheral 1 is the status port. A read returns `status_in` as sampled when the read executes, and a write changes nothing.
- R9: Peripheral 2 is the monitor select register. `mon_out` equals `mon_in[sel[3:0]]`, and a read returns the full byte last written.
- R10: Peripheral 3 is the test-mode enable register. A write sets `test_en`, and a read returns its value.
- R11: Peripherals 4 to 15 are unmapped. A read from one returns 0x00, and a write to one changes no peripheral.
- R12: After reset, TDO, `sw_out`, `test_en` and the monitor select are all 0, so `mon_out` follows `mon_in[0]`.
- R13: While select is low, shift, capture and update have no effect on the register, TDO or the peripherals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| tck_rst_n | input | 1 | Asynchronous active-low reset of the TCK-domain logic |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the register |
| usr_sel | input | 1 | User data register selected by the controller |
| usr_capture | input | 1 | Capture strobe |
| usr_shift | input | 1 | Shift strobe |
| usr_update | input | 1 | Update strobe |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the system-domain logic |
| status_in | input | 8 | Status byte read by peripheral 1 |
| mon_in | input | 16 | Internal signals available to the monitor multiplexer |
| mon_out | output | 1 | Selected monitor signal |
| sw_out | output | 8 | Virtual switch register |
| test_en | output | 8 | Test-mode enables |
| per_wr_stb | output | 1 | One-cycle write strobe |
| per_wr_addr | output | 4 | Peripheral number of the write |
| per_wr_data | output | 8 | Data byte of the write |

## Verification
The update edge flips the toggle, and two synchroniser flops and one edge flop follow in the system domain. The command pulse is therefore high in the second system cycle after that edge, `ST_DECODE` in the third, the strobe in the fourth, and the peripheral register changes at the end of the fourth. This puts every system-side result inside five system cycles of the update. The bench waits twelve system cycles after each update and then samples on a falling system edge. It counts strobes over that whole window, so both a missing pulse and a doubled pulse are seen. Read results and the command byte reach the port only on the next capture. For that reason, every scan first compares the word it shifts out against the state the model predicted after the previous command. TDO is sampled in the TCK-low phase, before the edge that shifts.

// File: rtl/jdb_pkg.sv
package jdb_pkg;

    // Operation codes carried in the command word.
    localparam int unsigned OPC_WRITE = 0;
    localparam int unsigned OPC_READ  = 1;

    // Peripheral numbers.
    localparam int unsigned PER_SWITCH = 0;
    localparam int unsigned PER_STATUS = 1;
    localparam int unsigned PER_MONSEL = 2;
    localparam int unsigned PER_TESTEN = 3;

    // Writable register slots and the peripheral number behind each one.
    localparam int unsigned NUM_RW    = 3;
    localparam int unsigned SLOT_SW   = 0;
    localparam int unsigned SLOT_MSEL = 1;
    localparam int unsigned SLOT_TEST = 2;

    function automatic int unsigned rw_slot_addr(input int unsigned slot);
        case (slot)
            SLOT_SW:   return PER_SWITCH;
            SLOT_MSEL: return PER_MONSEL;
            default:   return PER_TESTEN;
        endcase
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WRITE,
        ST_READ
    } cmd_state_e;

endpackage

// File: rtl/jdb_shift_reg.sv
module jdb_shift_reg #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTRL_W = 8,
    localparam int unsigned DR_W  = DATA_W + CTRL_W
) (
    input  logic              tck,
    input  logic              tck_rst_n,
    input  logic              tdi,
    input  logic              sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              tdo,
    output logic [DR_W-1:0]   hold_q,
    output logic              upd_tgl
);

    logic [DR_W-1:0] sr_q;

    // Scan path: capture has priority over shift.
    always_ff @(posedge tck or negedge tck_rst_n) begin
        if (!tck_rst_n) begin
            sr_q <= '0;
        end else if (sel && capture) begin
            sr_q <= {hold_q[DR_W-1 -: CTRL_W], rd_byte};
        end else if (sel && shift) begin
            sr_q <= {tdi, sr_q[DR_W-1:1]};
        end
    end

    // Command holding register and the toggle that reports a new command.
    always_ff @(posedge tck or negedge tck_rst_n) begin
        if (!tck_rst_n) begin
            hold_q  <= '0;
            upd_tgl <= 1'b0;
        end else if (sel && update) begin
            hold_q  <= sr_q;
            upd_tgl <= ~upd_tgl;
        end
    end

    assign tdo = sr_q[0];

    // R13: without select the scan register keeps its value.
    p_scan_quiet_r13: assert property (@(posedge tck) disable iff (!tck_rst_n)
        !(sel && (capture || shift)) |=> $stable(sr_q));

    // R6: the command is held across shifting and changes only on update.
    p_hold_on_update_r6: assert property (@(posedge tck) disable iff (!tck_rst_n)
        !(sel && update) |=> $stable(hold_q));

endmodule

// File: rtl/jdb_toggle_sync.sv
module jdb_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], tgl_in};
        end
    end

    assign pulse = chain_q[STAGES] ^ chain_q[STAGES-1];

    // R3: one toggle yields a single-cycle pulse.
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/jdb_cmd_fsm.sv
module jdb_cmd_fsm
    import jdb_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DR_W  = ADDR_W + OP_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_pulse,
    input  logic [DR_W-1:0]   cmd_word,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_byte
);

    cmd_state_e        state_q, state_d;
    logic [DR_W-1:0]   cmd_q;
    logic [ADDR_W-1:0] cmd_addr;
    logic [OP_W-1:0]   cmd_op;

    assign cmd_addr = cmd_q[DR_W-1 -: ADDR_W];
    assign cmd_op   = cmd_q[DATA_W +: OP_W];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_pulse) state_d = ST_DECODE;
            ST_DECODE: begin
                if (cmd_op == OP_W'(OPC_WRITE))     state_d = ST_WRITE;
                else if (cmd_op == OP_W'(OPC_READ)) state_d = ST_READ;
                else                                state_d = ST_IDLE;
            end
            ST_WRITE:  state_d = ST_IDLE;
            ST_READ:   state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        wr_stb = 1'b0;
        unique case (state_q)
            ST_IDLE:   wr_stb = 1'b0;
            ST_DECODE: wr_stb = 1'b0;
            ST_WRITE:  wr_stb = 1'b1;
            ST_READ:   wr_stb = 1'b0;
        endcase
    end

    assign wr_addr = cmd_addr;
    assign wr_data = cmd_q[DATA_W-1:0];
    assign rd_addr = cmd_addr;

    // The holding word is stable whenever the synchronised pulse is seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (state_q == ST_IDLE && cmd_pulse) begin
            cmd_q <= cmd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (state_q == ST_READ) begin
            rd_byte <= rd_data;
        end
    end

    // R3: a write strobe lasts exactly one cycle.
    p_wr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R5: a strobe only comes from a command with the write operation.
    p_wr_only_write_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> cmd_op == OP_W'(OPC_WRITE));

endmodule

// File: rtl/jdb_periph_bank.sv
module jdb_periph_bank
    import jdb_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned MON_W  = 16,
    localparam int unsigned MSEL_W = $clog2(MON_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] status_in,
    input  logic [MON_W-1:0]  mon_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sw_out,
    output logic [DATA_W-1:0] test_en,
    output logic              mon_out
);

    logic [NUM_RW*DATA_W-1:0] rw_flat;

    // One writable byte register per slot.
    for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_stb && wr_addr == ADDR_W'(rw_slot_addr(i))) begin
                q <= wr_data;
            end
        end
        assign rw_flat[i*DATA_W +: DATA_W] = q;
    end

    // Readback: unmapped numbers return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(PER_STATUS)) begin
            rd_data = status_in;
        end
        for (int k = 0; k < NUM_RW; k++) begin
            if (rd_addr == ADDR_W'(rw_slot_addr(k))) begin
                rd_data = rw_flat[k*DATA_W +: DATA_W];
            end
        end
    end

    logic [DATA_W-1:0] msel;
    assign sw_out  = rw_flat[SLOT_SW*DATA_W +: DATA_W];
    assign msel    = rw_flat[SLOT_MSEL*DATA_W +: DATA_W];
    assign test_en = rw_flat[SLOT_TEST*DATA_W +: DATA_W];
    assign mon_out = mon_in[msel[MSEL_W-1:0]];

    // R11: writes to unmapped numbers leave every register alone.
    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr > ADDR_W'(PER_TESTEN)) |=> $stable(rw_flat));

    // R8: the status port cannot be written.
    p_status_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == ADDR_W'(PER_STATUS)) |=> $stable(rw_flat));

endmodule

// File: rtl/jtag_dbg_bridge.sv
module jtag_dbg_bridge #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned OP_W        = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned MON_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              tck,
    input  logic              tck_rst_n,
    input  logic              tdi,
    output logic              tdo,
    input  logic              usr_sel,
    input  logic              usr_capture,
    input  logic              usr_shift,
    input  logic              usr_update,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic [DATA_W-1:0] status_in,
    input  logic [MON_W-1:0]  mon_in,
    output logic              mon_out,
    output logic [DATA_W-1:0] sw_out,
    output logic [DATA_W-1:0] test_en,
    output logic              per_wr_stb,
    output logic [ADDR_W-1:0] per_wr_addr,
    output logic [DATA_W-1:0] per_wr_data
);

    localparam int unsigned CTRL_W = ADDR_W + OP_W;
    localparam int unsigned DR_W   = CTRL_W + DATA_W;

    logic [DR_W-1:0]   hold_word;
    logic              upd_tgl;
    logic              cmd_pulse;
    logic [DATA_W-1:0] rd_byte;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;

    jdb_shift_reg #(
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) u_shift (
        .tck       (tck),
        .tck_rst_n (tck_rst_n),
        .tdi       (tdi),
        .sel       (usr_sel),
        .capture   (usr_capture),
        .shift     (usr_shift),
        .update    (usr_update),
        .rd_byte   (rd_byte),
        .tdo       (tdo),
        .hold_q    (hold_word),
        .upd_tgl   (upd_tgl)
    );

    jdb_toggle_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (sys_clk),
        .rst_n  (sys_rst_n),
        .tgl_in (upd_tgl),
        .pulse  (cmd_pulse)
    );

    jdb_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .OP_W   (OP_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (sys_clk),
        .rst_n     (sys_rst_n),
        .cmd_pulse (cmd_pulse),
        .cmd_word  (hold_word),
        .rd_data   (rd_data),
        .wr_stb    (per_wr_stb),
        .wr_addr   (per_wr_addr),
        .wr_data   (per_wr_data),
        .rd_addr   (rd_addr),
        .rd_byte   (rd_byte)
    );

    jdb_periph_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MON_W  (MON_W)
    ) u_bank (
        .clk       (sys_clk),
        .rst_n     (sys_rst_n),
        .wr_stb    (per_wr_stb),
        .wr_addr   (per_wr_addr),
        .wr_data   (per_wr_data),
        .rd_addr   (rd_addr),
        .status_in (status_in),
        .mon_in    (mon_in),
        .rd_data   (rd_data),
        .sw_out    (sw_out),
        .test_en   (test_en),
        .mon_out   (mon_out)
    );

endmodule

// File: tb/jtag_dbg_bridge_bench.sv
`timescale 1ns/1ps
module jtag_dbg_bridge_bench;

    logic        tck = 1'b0, tck_rst_n = 1'b0, tdi = 1'b0, tdo;
    logic        usr_sel = 1'b0, usr_capture = 1'b0, usr_shift = 1'b0, usr_update = 1'b0;
    logic        sys_clk = 1'b0, sys_rst_n = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic [15:0] mon_in = 16'h0000;
    logic        mon_out, per_wr_stb;
    logic [7:0]  sw_out, test_en, per_wr_data;
    logic [3:0]  per_wr_addr;

    jtag_dbg_bridge u_jtag_dbg_bridge (
        .tck(tck), .tck_rst_n(tck_rst_n), .tdi(tdi), .tdo(tdo),
        .usr_sel(usr_sel), .usr_capture(usr_capture), .usr_shift(usr_shift),
        .usr_update(usr_update), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .status_in(status_in), .mon_in(mon_in), .mon_out(mon_out),
        .sw_out(sw_out), .test_en(test_en), .per_wr_stb(per_wr_stb),
        .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data)
    );

    always #2.5 sys_clk = ~sys_clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Strobe monitor, sampled away from the active edge.
    int         stb_cnt = 0;
    logic [3:0] stb_addr = '0;
    logic [7:0] stb_data = '0;
    always @(negedge sys_clk) begin
        if (per_wr_stb) begin
            stb_cnt++;
            stb_addr = per_wr_addr;
            stb_data = per_wr_data;
        end
    end

    // Model of the expected state.
    logic [7:0] m_sw = 0, m_test = 0, m_msel = 0, m_rd = 0, m_ctrl = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0:    return m_sw;
            4'd1:    return status_in;
            4'd2:    return m_msel;
            4'd3:    return m_test;
            default: return 8'h00;
        endcase
    endfunction

    task automatic tck_pulse();
        #10 tck = 1'b1;
        #10 tck = 1'b0;
    endtask

    task automatic sys_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge sys_clk);
    endtask

    task automatic scan(input logic [15:0] w, input bit upd, output logic [15:0] got);
        usr_sel = 1'b1; usr_capture = 1'b1;
        tck_pulse();
        usr_capture = 1'b0; usr_shift = 1'b1;
        for (int i = 0; i < 16; i++) begin
            #2 got[i] = tdo;
            tdi = w[i];
            tck_pulse();
        end
        usr_shift = 1'b0;
        if (upd) begin
            usr_update = 1'b1;
            tck_pulse();
            usr_update = 1'b0;
        end
        usr_sel = 1'b0;
    endtask

    task automatic run_cmd(input logic [15:0] w, input bit upd);
        logic [15:0] got;
        int          base;
        int          exp_stb;
        base    = stb_cnt;
        exp_stb = 0;
        scan(w, upd, got);
        chk("R1 R2 R4 captured word", got, {m_ctrl, m_rd});
        if (upd) begin
            m_ctrl = w[15:8];
            if (w[11:8] == 4'h0) begin
                exp_stb = 1;
                case (w[15:12])
                    4'd0: m_sw   = w[7:0];
                    4'd2: m_msel = w[7:0];
                    4'd3: m_test = w[7:0];
                    default: ;
                endcase
            end else if (w[11:8] == 4'h1) begin
                m_rd = exp_read(w[15:12]);
            end
        end
        sys_wait(12);
        chk("R3 R5 R6 strobe count", stb_cnt - base, exp_stb);
        if (exp_stb == 1) begin
            chk("R3 strobe addr", {28'd0, stb_addr}, {28'd0, w[15:12]});
            chk("R3 strobe data", {24'd0, stb_data}, {24'd0, w[7:0]});
        end
        chk("R7 R11 sw_out", {24'd0, sw_out}, {24'd0, m_sw});
        chk("R10 R11 test_en", {24'd0, test_en}, {24'd0, m_test});
        chk("R9 mon_out", {31'd0, mon_out}, {31'd0, mon_in[m_msel[3:0]]});
    endtask

    initial begin
        logic [15:0] got;
        void'($urandom(32'h5eed_0042));
        mon_in = 16'hA5C3;
        sys_wait(10);
        tck_rst_n = 1'b1;
        sys_rst_n = 1'b1;
        sys_wait(4);

        // R12 reset state
        chk("R12 tdo", {31'd0, tdo}, 32'd0);
        chk("R12 sw_out", {24'd0, sw_out}, 32'd0);
        chk("R12 test_en", {24'd0, test_en}, 32'd0);
        chk("R12 mon_out", {31'd0, mon_out}, {31'd0, mon_in[0]});

        // Directed cases.
        run_cmd(16'h2034, 1'b1);          // R9 write monitor select
        run_cmd(16'h00A5, 1'b1);          // R7 write switch
        run_cmd(16'h0100, 1'b1);          // R4 R7 read switch
        status_in = 8'h6B;
        run_cmd(16'h1100, 1'b1);          // R8 read status
        run_cmd(16'h10FF, 1'b1);          // R8 write status ignored
        run_cmd(16'h3012, 1'b1);          // R10 write test enables
        run_cmd(16'h3100, 1'b1);          // R10 read back
        run_cmd(16'h9100, 1'b1);          // R11 unmapped read -> 0
        run_cmd(16'h70EE, 1'b1);          // R11 unmapped write
        run_cmd(16'h0233, 1'b1);          // R5 bad opcode
        run_cmd(16'h0FCC, 1'b1);          // R5 bad opcode
        run_cmd(16'h0077, 1'b0);          // R6 no update
        run_cmd(16'h2100, 1'b1);          // R9 read monitor select

        // R13: strobes without select have no effect.
        begin
            int base;
            base = stb_cnt;
            usr_sel = 1'b1; usr_capture = 1'b1;
            tck_pulse();
            usr_capture = 1'b0; usr_sel = 1'b0;
            usr_shift = 1'b1; tdi = 1'b1;
            for (int i = 0; i < 5; i++) tck_pulse();
            usr_shift = 1'b0; usr_capture = 1'b1; usr_update = 1'b1;
            tck_pulse();
            usr_capture = 1'b0; usr_update = 1'b0;
            #2 chk("R13 tdo held", {31'd0, tdo}, {31'd0, m_rd[0]});
            usr_sel = 1'b1; usr_shift = 1'b1; tdi = 1'b0;
            for (int i = 0; i < 16; i++) begin
                #2 got[i] = tdo;
                tck_pulse();
            end
            usr_shift = 1'b0; usr_sel = 1'b0;
            chk("R13 register held", {16'd0, got}, {16'd0, m_ctrl, m_rd});
            sys_wait(12);
            chk("R13 no strobe", stb_cnt - base, 0);
            chk("R13 sw_out", {24'd0, sw_out}, {24'd0, m_sw});
        end

        // Constrained random commands.
        for (int n = 0; n < 60; n++) begin
            logic [3:0]  a;
            logic [3:0]  op;
            int unsigned pick;
            a    = 4'($urandom_range(0, 7));
            pick = $urandom_range(0, 99);
            op   = (pick < 45) ? 4'h0 : (pick < 90) ? 4'h1 : 4'($urandom_range(2, 15));
            status_in = 8'($urandom);
            mon_in    = 16'($urandom);
            run_cmd({a, op, 8'($urandom)}, ($urandom_range(0, 9) != 0));
        end
        run_cmd(16'h0100, 1'b1);          // final word collects last result

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule